// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal and vertical sync, data enable, a pixel strobe derived from the source clock, pixel and line position counters, and a one-cycle marker at the start of every frame. Each axis takes four fields: sync width, back porch, active size and front porch. Each field holds the wanted count minus one. A divider field, also written as divisor minus one, sets how many source clock cycles make up one pixel. A bypass selection makes every source cycle a pixel.

Separate inversion inputs make hsync, vsync and data enable active-low. A fourth inversion input is passed to the pad logic, which uses it to choose falling-edge data sampling. The global enable and the divider settings go into shadow registers. While the raster runs, new values take effect only when a frame wraps. A frame interrupt pending flag is set at the start of each frame and cleared by a write-one pulse.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, every output is 0 and the irq pending flag is clear.
- R2: A line starts with the hsync pulse, which lasts h_sync+1 pixels. Back porch, active and front porch follow. A line lasts h_sync+h_back+h_act+h_front+4 pixels.
- R3: A frame uses the same order counted in lines. vsync is active for the whole of the first v_sync+1 lines. A frame lasts v_sync+v_back+v_act+v_front+4 lines.
- R4: Data enable is active only when both axes are in their active segment. That segment starts at position sync+back+2 and lasts act+1 positions.
- R5: pix_x_o and pix_y_o report the position inside the line and the frame, where 0 is the first sync position. frame_start_o pulses on the first source cycle of position (0,0).
- R6: When cfg_div_en is 1, each pixel lasts cfg_div_m1+1 source cycles, up to 256. pix_tick_o is high on the last cycle of each pixel.
- R7: When cfg_div_en is 0, every source cycle is one pixel and cfg_div_m1 has no effect.
- R8: An inversion bit set to 1 makes its output active-low: cfg_inv_hsync for hsync, cfg_inv_vsync for vsync, cfg_inv_de for data enable. sample_fall_o repeats cfg_inv_pclk one cycle later.
- R9: While running, changes to cfg_enable, cfg_div_en and cfg_div_m1 apply only at the frame wrap. While stopped, they apply on the next cycle.
- R10: While stopped, hsync, vsync and de sit at their inactive levels, with polarity applied. Positions are 0. pix_tick_o and frame_start_o stay low.
- R11: When irq_en is 1, irq_pend_o is set at frame start. It stays set until an irq_clr pulse. When set and clear happen in the same cycle, set wins. With irq_en at 0, the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global output enable (shadowed) |
| cfg_div_en | input | 1 | 1 = divide the clock, 0 = 1:1 pixel clock (shadowed) |
| cfg_div_m1 | input | DW | Divisor minus one (shadowed) |
| cfg_h_sync_m1 | input | FW | hsync width minus one |
| cfg_h_back_m1 | input | FW | Horizontal back porch minus one |
| cfg_h_act_m1 | input | FW | Active pixels minus one |
| cfg_h_front_m1 | input | FW | Horizontal front porch minus one |
| cfg_v_sync_m1 | input | FW | vsync width in lines minus one |
| cfg_v_back_m1 | input | FW | Vertical back porch minus one |
| cfg_v_act_m1 | input | FW | Active lines minus one |
| cfg_v_front_m1 | input | FW | Vertical front porch minus one |
| cfg_inv_hsync | input | 1 | Active-low hsync |
| cfg_inv_vsync | input | 1 | Active-low vsync |
| cfg_inv_de | input | 1 | Active-low data enable |
| cfg_inv_pclk | input | 1 | Request falling-edge data sampling |
| irq_en | input | 1 | Frame interrupt enable |
| irq_clr | input | 1 | Write-one pulse that clears the pending flag |
| pix_tick_o | output | 1 | Last source cycle of a pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | FW+2 | Position in line |
| pix_y_o | output | FW+2 | Line in frame |
| frame_start_o | output | 1 | Frame start pulse |
| sample_fall_o | output | 1 | Falling-edge sampling select |
| irq_pend_o | output | 1 | Frame interrupt pending |

## Verification
Some properties are checked on every cycle. Each axis counter must wrap after its last position. The divider count must stay within the shadowed divisor. The shadow registers must hold while a frame is in progress. Data enable must never overlap an active sync. frame_start must coincide with position zero. The pending flag must follow its set and clear rules.

Other behaviour only the bench scenarios can show. These are the exact segment lengths produced by the minus-one encoding, the pixel period for bypass, small and maximum divisors, a divider change and a disable that each wait for the frame wrap, inverted polarity, and the interrupt flag being cleared and set again.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;
endpackage

// File: rtl/lcd_tg_div.sv
module lcd_tg_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          bypass,
  input  logic [DW-1:0] div_m1,
  output logic          tick,
  output logic          first
);
  logic [DW-1:0] cnt;

  assign tick  = run && (bypass || cnt >= div_m1);
  assign first = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R6
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !bypass) |-> (cnt <= div_m1));

  // R7
  div_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (run && bypass) |-> (cnt == '0));
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int FW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          adv,
  input  logic [FW-1:0] sync_m1,
  input  logic [FW-1:0] back_m1,
  input  logic [FW-1:0] act_m1,
  input  logic [FW-1:0] front_m1,
  output logic [FW+1:0] pos,
  output logic          at_end,
  output seg_e          seg
);
  localparam int PW = FW + 2;

  logic [PW-1:0] sync_e, back_e, act_e, last_e;

  always_comb begin
    sync_e = PW'(sync_m1);
    back_e = sync_e + PW'(back_m1) + PW'(1);
    act_e  = back_e + PW'(act_m1) + PW'(1);
    last_e = act_e + PW'(front_m1) + PW'(1);
  end

  always_comb begin
    if (pos <= sync_e)      seg = SEG_SYNC;
    else if (pos <= back_e) seg = SEG_BACK;
    else if (pos <= act_e)  seg = SEG_ACT;
    else                    seg = SEG_FRONT;
  end

  assign at_end = (pos >= last_e);

  always_ff @(posedge clk) begin
    if (rst || !run) pos <= '0;
    else if (adv)    pos <= at_end ? '0 : pos + 1'b1;
  end

  // R2
  axis_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && at_end) |=> (pos == '0));

  // R10
  axis_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pos == '0));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int FW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_enable,
  input  logic          cfg_div_en,
  input  logic [DW-1:0] cfg_div_m1,
  input  logic [FW-1:0] cfg_h_sync_m1,
  input  logic [FW-1:0] cfg_h_back_m1,
  input  logic [FW-1:0] cfg_h_act_m1,
  input  logic [FW-1:0] cfg_h_front_m1,
  input  logic [FW-1:0] cfg_v_sync_m1,
  input  logic [FW-1:0] cfg_v_back_m1,
  input  logic [FW-1:0] cfg_v_act_m1,
  input  logic [FW-1:0] cfg_v_front_m1,
  input  logic          cfg_inv_hsync,
  input  logic          cfg_inv_vsync,
  input  logic          cfg_inv_de,
  input  logic          cfg_inv_pclk,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          pix_tick_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [FW+1:0] pix_x_o,
  output logic [FW+1:0] pix_y_o,
  output logic          frame_start_o,
  output logic          sample_fall_o,
  output logic          irq_pend_o
);
  localparam int PW = FW + 2;

  // shadow copies of the enable and divider settings
  logic          run_q, byp_q;
  logic [DW-1:0] div_q;

  logic          tick, first;
  logic [PW-1:0] h_pos, v_pos;
  logic          h_end, v_end;
  seg_e          h_seg, v_seg;
  logic          frame_wrap, upd, fs_cond, pend_set;

  assign frame_wrap = tick && h_end && v_end;
  assign upd        = !run_q || frame_wrap;
  assign fs_cond    = run_q && first && (h_pos == '0) && (v_pos == '0);
  assign pend_set   = fs_cond && irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      byp_q <= 1'b1;
      div_q <= '0;
    end else if (upd) begin
      run_q <= cfg_enable;
      byp_q <= !cfg_div_en;
      div_q <= cfg_div_m1;
    end
  end

  lcd_tg_div #(.DW(DW)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .bypass (byp_q),
    .div_m1 (div_q),
    .tick   (tick),
    .first  (first)
  );

  lcd_tg_axis #(.FW(FW)) u_hax (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .adv      (tick),
    .sync_m1  (cfg_h_sync_m1),
    .back_m1  (cfg_h_back_m1),
    .act_m1   (cfg_h_act_m1),
    .front_m1 (cfg_h_front_m1),
    .pos      (h_pos),
    .at_end   (h_end),
    .seg      (h_seg)
  );

  lcd_tg_axis #(.FW(FW)) u_vax (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .adv      (tick && h_end),
    .sync_m1  (cfg_v_sync_m1),
    .back_m1  (cfg_v_back_m1),
    .act_m1   (cfg_v_act_m1),
    .front_m1 (cfg_v_front_m1),
    .pos      (v_pos),
    .at_end   (v_end),
    .seg      (v_seg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_tick_o    <= 1'b0;
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      de_o          <= 1'b0;
      pix_x_o       <= '0;
      pix_y_o       <= '0;
      frame_start_o <= 1'b0;
      sample_fall_o <= 1'b0;
      irq_pend_o    <= 1'b0;
    end else begin
      pix_tick_o    <= tick;
      hsync_o       <= cfg_inv_hsync ^ (run_q && h_seg == SEG_SYNC);
      vsync_o       <= cfg_inv_vsync ^ (run_q && v_seg == SEG_SYNC);
      de_o          <= cfg_inv_de ^ (run_q && h_seg == SEG_ACT && v_seg == SEG_ACT);
      pix_x_o       <= h_pos;
      pix_y_o       <= v_pos;
      frame_start_o <= fs_cond;
      sample_fall_o <= cfg_inv_pclk;
      if (pend_set)     irq_pend_o <= 1'b1;
      else if (irq_clr) irq_pend_o <= 1'b0;
    end
  end

  // R4
  de_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (de_o != $past(cfg_inv_de)) |->
      (hsync_o == $past(cfg_inv_hsync) && vsync_o == $past(cfg_inv_vsync)));

  // R5
  fs_origin_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (pix_x_o == '0 && pix_y_o == '0));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !frame_wrap) |=> (run_q && $stable(div_q) && $stable(byp_q)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (!pix_tick_o && !frame_start_o));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !pend_set) |=> !irq_pend_o);

  // R11
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    pend_set |=> irq_pend_o);
endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  localparam int FW = 11;
  localparam int DW = 8;
  localparam int HT = 9;
  localparam int VT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 0, cfg_div_en = 0;
  logic [DW-1:0] cfg_div_m1 = 0;
  logic [FW-1:0] h_s = 1, h_b = 0, h_a = 3, h_f = 1;
  logic [FW-1:0] v_s = 0, v_b = 1, v_a = 2, v_f = 0;
  logic inv_h = 0, inv_v = 0, inv_d = 0, inv_p = 0;
  logic irq_en = 0, irq_clr = 0;
  logic pix_tick_o, hsync_o, vsync_o, de_o, frame_start_o, sample_fall_o, irq_pend_o;
  logic [FW+1:0] pix_x_o, pix_y_o;

  int n_chk = 0, n_fail = 0;
  int mh = 0, mv = 0, md = 0, dcur = 1;
  bit mon = 0, mrun = 0;
  string stag = "";

  always #4 clk = ~clk;

  lcd_timing_gen #(.FW(FW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_div_en(cfg_div_en),
    .cfg_div_m1(cfg_div_m1),
    .cfg_h_sync_m1(h_s), .cfg_h_back_m1(h_b), .cfg_h_act_m1(h_a), .cfg_h_front_m1(h_f),
    .cfg_v_sync_m1(v_s), .cfg_v_back_m1(v_b), .cfg_v_act_m1(v_a), .cfg_v_front_m1(v_f),
    .cfg_inv_hsync(inv_h), .cfg_inv_vsync(inv_v), .cfg_inv_de(inv_d), .cfg_inv_pclk(inv_p),
    .irq_en(irq_en), .irq_clr(irq_clr),
    .pix_tick_o(pix_tick_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .frame_start_o(frame_start_o),
    .sample_fall_o(sample_fall_o), .irq_pend_o(irq_pend_o)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, stag, act, exp, $time);
    end
  endtask

  // expected raster values derived from the field settings of the requirements
  task automatic compare();
    bit eh, ev, ed;
    eh = mrun && mh <= 1;
    ev = mrun && mv == 0;
    ed = mrun && mh >= 3 && mh <= 6 && mv >= 3 && mv <= 5;
    chk(hsync_o, inv_h ^ eh, "R2 hsync");
    chk(vsync_o, inv_v ^ ev, "R3 vsync");
    chk(de_o, inv_d ^ ed, "R4 de");
    chk(pix_x_o, mrun ? mh : 0, "R5 pix_x");
    chk(pix_y_o, mrun ? mv : 0, "R5 pix_y");
    chk(frame_start_o, mrun && mh == 0 && mv == 0 && md == 0, "R5 frame_start");
    chk(pix_tick_o, mrun && md == dcur - 1, dcur == 1 ? "R7 tick" : "R6 tick");
  endtask

  task automatic advance();
    if (mrun) begin
      md++;
      if (md == dcur) begin
        md = 0; mh++;
        if (mh == HT) begin
          mh = 0; mv++;
          if (mv == VT) begin
            mv = 0;
            dcur = cfg_div_en ? int'(cfg_div_m1) + 1 : 1;
            mrun = cfg_enable;
          end
        end
      end
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mon) begin compare(); advance(); end
    end
  endtask

  task automatic sync_start();
    mon = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (frame_start_o) break;
    end
    mh = 0; mv = 0; md = 0; mrun = 1; mon = 1;
    dcur = cfg_div_en ? int'(cfg_div_m1) + 1 : 1;
    compare(); advance();
  endtask

  task automatic idle_check(input string req);
    chk(hsync_o, inv_h, {req, " idle hsync"});
    chk(vsync_o, inv_v, {req, " idle vsync"});
    chk(de_o, inv_d, {req, " idle de"});
    chk(pix_x_o, 0, {req, " idle pix_x"});
    chk(pix_tick_o, 0, {req, " idle tick"});
    chk(frame_start_o, 0, {req, " idle frame_start"});
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    stag = "reset";
    // R1
    chk(hsync_o, 0, "R1 hsync"); chk(vsync_o, 0, "R1 vsync"); chk(de_o, 0, "R1 de");
    chk(irq_pend_o, 0, "R1 irq_pend"); chk(frame_start_o, 0, "R1 frame_start");

    // R7: bypass, divider field set but ignored
    stag = "bypass";
    cfg_div_en = 0; cfg_div_m1 = 2; cfg_enable = 1;
    sync_start();
    step(2 * HT * VT);
    // R11: never set when irq_en is 0
    chk(irq_pend_o, 0, "R11 no irq when disabled");

    // R9, R6: divider change mid-frame, applied at the next wrap
    stag = "R9 div change";
    step(20);
    cfg_div_en = 1; cfg_div_m1 = 2;
    step(HT * VT * 3 * 2 + 40);

    // R9, R10: disable mid-frame, outputs stop only at the wrap
    stag = "R9 disable";
    step(17);
    cfg_enable = 0;
    step(HT * VT * 3 + 30);
    mon = 0;
    idle_check("R10");

    // R8: inverted polarity while stopped, then running with divisor 2
    stag = "R8 polarity";
    inv_h = 1; inv_v = 1; inv_d = 1; inv_p = 1;
    step(2);
    idle_check("R8");
    chk(sample_fall_o, 1, "R8 sample_fall");
    irq_en = 1; cfg_div_m1 = 1; cfg_enable = 1;
    sync_start();
    // R11: set at frame start
    chk(irq_pend_o, 1, "R11 pend at frame start");
    step(5);
    irq_clr = 1; step(1); irq_clr = 0;
    chk(irq_pend_o, 0, "R11 pend cleared");
    step(HT * VT * 2 - 8);
    chk(irq_pend_o, 0, "R11 pend held clear");
    step(2 * HT * VT * 2);
    chk(irq_pend_o, 1, "R11 pend set again");

    // R6: largest divisor, 256 cycles per pixel
    stag = "R6 max divisor";
    cfg_enable = 0;
    step(HT * VT * 2 + 4);
    mon = 0;
    inv_h = 0; inv_v = 0; inv_d = 0; inv_p = 0;
    cfg_div_m1 = 8'd255; cfg_enable = 1;
    sync_start();
    step(1200);
    chk(sample_fall_o, 0, "R8 sample_fall low");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule